// File: doc/BRIEF.md
# Watchdog Timer with Sticky Enable

This block is a watchdog timer for a small microcontroller. Software controls it through one 8-bit control register. The register sets the watchdog running, restarts its count, chooses whether it keeps counting while the core is idle, and picks a prescaler ratio. The system clock is divided by the chosen ratio, and each prescaler tick advances a wide watchdog counter. When that counter wraps, the block emits a single-clock reset pulse. Software must write the restart bit often enough to keep the counter from wrapping.

Once the watchdog is running, software cannot stop it; only the synchronous system reset does. The restart request is a one-shot: the hardware drops it again by itself. A change of prescaler ratio is picked up only at the start of a prescaler period, so no tick is ever shortened or stretched by a partial period.

Top module: `wdog_ctl`

## Requirements
- R1: Control register fields are: bit 5 run enable, bit 4 restart, bit 3 count-in-idle, bits 2:0 prescaler code. Bits 7 and 6 always read 0, and writing 1 to them changes nothing.
- R2: Synchronous reset clears every register bit, so a read returns 0x00, the watchdog is stopped with code 000, and the reset output is low.
- R3: Once the run-enable bit is written to 1, a later write of 0 leaves it at 1. Only the system reset clears it.
- R4: A write with bit 4 set reads back bit 4 = 1 for exactly one cycle, then 0. In the cycle after that write, the prescaler and the watchdog counter both return to 0. The next pulse then comes 2^CNT_W * 2^(code+1) clock edges after that clearing edge.
- R5: The prescaler divides by 2^(code+1), giving 2 for code 000 up to 256 for code 111. The first pulse is seen 2^CNT_W * 2^(code+1) rising edges after the edge that captured the enabling write. Later pulses repeat at the same interval.
- R6: Each overflow produces a reset pulse exactly one clock long.
- R7: While the idle input is high and the count-in-idle bit is 0, both counters hold their values, so the pulse is delayed by the number of idle cycles. With the count-in-idle bit set to 1, the idle input has no effect.
- R8: A new prescaler code is applied only at a period boundary. The period in progress finishes with the old ratio, and the following periods use the new one.
- R9: While the run-enable bit is 0, no reset pulse is ever produced, whatever the other bits hold.
- R10: The watchdog counter is CNT_W bits wide, 15 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Data written to the control register |
| rd_data | output | 8 | Current control register contents |
| idle_in | input | 1 | High while the core is in idle mode |
| wdt_rst_o | output | 1 | One-clock reset pulse on watchdog overflow |

## Verification
The assertions assume that the idle input and the register write port are synchronous to the clock and steady around each rising edge. They also assume that the system reset is held for at least one edge before any check counts. The bench changes every input at the falling edge and applies a multi-cycle reset between scenarios, so each scenario starts from the cleared state. To keep runs short, the bench builds the watchdog counter with a reduced width. All expected pulse times are still computed from the general period formula.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W   = 8;
  localparam int PSEL_W  = 3;
  localparam int PRE_W   = 2 ** PSEL_W;

  localparam int BIT_EN      = 5;
  localparam int BIT_RESTART = 4;
  localparam int BIT_RUNIDLE = 3;

  typedef struct packed {
    logic              en;
    logic              restart;
    logic              run_idle;
    logic [PSEL_W-1:0] psel;
  } wd_ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output wd_ctl_t          ctl
);
  localparam int FREE_W = REG_W - 3 - PSEL_W;

  logic unused_hi;
  assign unused_hi = ^wr_data[REG_W-1:BIT_EN+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else begin
      ctl.restart <= wr_en & wr_data[BIT_RESTART];
      if (wr_en) begin
        ctl.en       <= ctl.en | wr_data[BIT_EN];
        ctl.run_idle <= wr_data[BIT_RUNIDLE];
        ctl.psel     <= wr_data[PSEL_W-1:0];
      end
    end
  end

  assign rd_data = {{FREE_W{1'b0}}, ctl.en, ctl.restart, ctl.run_idle, ctl.psel};

  // R3: run enable stays set until system reset
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    ctl.en |=> ctl.en);

  // R4: restart request is a one-shot unless written again
  a_r4_restart_oneshot: assert property (@(posedge clk) disable iff (rst)
    (ctl.restart && !wr_en) |=> !ctl.restart);
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              clear,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam logic [PSEL_W-1:0] CODE_MAX = '1;
  localparam logic [PRE_W-1:0]  ONES     = '1;

  logic [PRE_W-1:0]  pre_q;
  logic [PSEL_W-1:0] code_q;
  logic [PRE_W-1:0]  lim;

  // terminal value for division by 2^(code+1)
  assign lim  = ONES >> (CODE_MAX - code_q);
  assign tick = active & ~clear & (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (active) begin
      if (tick) pre_q <= '0;
      else      pre_q <= pre_q + 1'b1;
    end
  end

  // code is taken over only while the prescaler sits at a period start
  always_ff @(posedge clk) begin
    if (rst)               code_q <= '0;
    else if (pre_q == '0)  code_q <= psel;
  end

  // R8: ratio never changes inside a running period
  a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
    (pre_q != '0) |=> $stable(code_q));

  // R4: clear returns the prescaler to a period start
  a_r4_pre_cleared: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= tick & (cnt_o == CNT_MAX);
      if (tick) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R6: reset pulse lasts one clock
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !ovf_o);

  // R4: clear empties the counter and drops any pulse
  a_r4_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_o == '0) && !ovf_o);

  // R5: a pulse comes only out of a wrap
  a_r5_pulse_on_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_o == '0));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             idle_in,
  output logic             wdt_rst_o
);
  wd_ctl_t          ctl;
  logic             active;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  wdog_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ctl     (ctl)
  );

  // idle stalls counting unless count-in-idle is set
  assign active = ctl.en & ~(idle_in & ~ctl.run_idle);

  wdog_prescale u_pre (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .clear  (ctl.restart),
    .psel   (ctl.psel),
    .tick   (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (ctl.restart),
    .tick  (tick),
    .cnt_o (cnt),
    .ovf_o (wdt_rst_o)
  );

  // R7: idle without count-in-idle freezes the watchdog count
  a_r7_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    (idle_in && !ctl.run_idle && !ctl.restart) |=> $stable(cnt));

  // R9: stopped watchdog never resets
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !ctl.en |-> !wdt_rst_o);
endmodule

// File: tb/wdog_ctl_test.sv
module wdog_ctl_test;
  localparam int CW    = 6;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       idle_in = 1'b0;
  logic [7:0] rd_data;
  logic       wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_pulse = -10;
  int pulses = 0;
  int exp_q[$];
  string cur_tag = "R5";

  wdog_ctl #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .idle_in(idle_in), .wdt_rst_o(wdt_rst_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(input int code);
    return (1 << CW) * (2 << code);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected pulse times and compares
  always @(negedge clk) begin
    if (!rst && wdt_rst_o) begin
      pulses++;
      check(cyc != last_pulse + 1, "R6 pulse width", cyc - last_pulse, 2);
      last_pulse = cyc;
      if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected pulse"}, cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, {cur_tag, " pulse time"}, cyc, e);
      end
    end
  end

  // watchdog of the bench
  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
  endtask

  // called at a falling edge; returns the capturing edge number
  task automatic wr(input logic [7:0] d, output int w);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 w = cyc;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string tag);
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 40000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, {tag, " expected pulse missing"}, exp_q.size(), 0);
  endtask

  initial begin
    int w, c, p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    rd_chk(8'h00, "R2 reset read");
    check(wdt_rst_o == 1'b0, "R2 reset output", wdt_rst_o, 0);

    // R1 high bits ignored, R9 disabled stays quiet
    cur_tag = "R9";
    wr(8'hC7, w);
    rd_chk(8'h07, "R1 bits 7:6 ignored");
    p0 = pulses;
    repeat (300) @(negedge clk);
    check(pulses == p0, "R9 no pulse while stopped", pulses - p0, 0);
    do_reset();

    // R5 base period and repetition, R3 sticky enable
    cur_tag = "R5";
    wr(8'h20, w);
    exp_q.push_back(w + period(0));
    exp_q.push_back(w + 2 * period(0));
    rd_chk(8'h20, "R1 enable readback");
    repeat (10) @(negedge clk);
    wr(8'h00, c);
    rd_chk(8'h20, "R3 enable sticky");
    drain("R5");
    do_reset();
    rd_chk(8'h00, "R2 reset clears enable");

    // R4 restart
    cur_tag = "R4";
    wr(8'h20, w);
    repeat (60) @(negedge clk);
    wr(8'h30, c);
    rd_chk(8'h30, "R4 restart reads 1 for one cycle");
    @(negedge clk);
    rd_chk(8'h20, "R4 restart self-clears");
    exp_q.push_back(c + 1 + period(0));
    drain("R4");
    do_reset();

    // R7 idle freezes count when count-in-idle is 0
    cur_tag = "R7";
    wr(8'h20, w);
    exp_q.push_back(w + period(0) + 50);
    repeat (20) @(negedge clk);
    idle_in = 1'b1;
    repeat (50) @(negedge clk);
    idle_in = 1'b0;
    drain("R7 freeze");
    do_reset();

    // R7 idle ignored when count-in-idle is 1
    wr(8'h28, w);
    rd_chk(8'h28, "R1 count-in-idle readback");
    exp_q.push_back(w + period(0));
    repeat (20) @(negedge clk);
    idle_in = 1'b1;
    repeat (30) @(negedge clk);
    idle_in = 1'b0;
    drain("R7 run in idle");
    do_reset();

    // R5 largest and middle ratios
    cur_tag = "R5 code7";
    wr(8'h27, w);
    exp_q.push_back(w + period(7));
    drain("R5 code7");
    do_reset();
    cur_tag = "R5 code3";
    wr(8'h23, w);
    exp_q.push_back(w + period(3));
    drain("R5 code3");
    do_reset();

    // R8 code change mid-period: code 1 then code 0
    cur_tag = "R8";
    wr(8'h21, w);
    repeat (40) @(negedge clk);
    wr(8'h20, c);
    begin
      int m;
      m = (c - w - 1) / 4;
      exp_q.push_back(w + 4 * (m + 1) + 2 * ((1 << CW) - 1 - m));
    end
    drain("R8");
    do_reset();
    // R10 counter width default is exercised by the period formula with CW
    check(period(0) == (1 << CW) * 2, "R10 period formula", period(0), (1 << CW) * 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule